// File: doc/BRIEF.md
# Qualified Fault Flag Logic

This block merges three fault sources of a low-side power switch into one active-low fault flag: an over-current comparator bit, an under-current comparator bit and a die temperature code. The flag is high in normal operation. It goes low while any qualified fault is present.

Each current comparator passes through its own debounce filter. The filter has separate set and release delays, given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

The comparator bits are only meaningful while the switch conducts. For that reason a current fault is counted and reported only while the switch-on command is high. Current faults are not latched, so during pulse-width modulation the flag is pulsed in step with the on-time.

The temperature code is compared against a hot threshold and a lower cool threshold, which gives hysteresis. While the thermal fault is held, the flag is low and the switch command passed to the power stage is forced off.

Top module: `fault_flag_qual`

## Requirements
- R1: After reset, with no fault input present, `flag_n` is 1 and `sw_out` follows `sw_on`.
- R2: An over-current fault qualifies after `oc_cmp` and `sw_on` have both been high at OC_SET rising edges in a row (500 cycles at defaults). From then on `flag_n` is 0 while `sw_on` is high.
- R3: A qualified over-current fault is released after OC_CLR consecutive edges (500 cycles) at which `oc_cmp` and `sw_on` are not both high. Until then the fault is still reported whenever `sw_on` is high.
- R4: An under-current fault sets after UC_SET consecutive qualifying edges (1000 cycles) and releases after UC_CLR consecutive non-qualifying edges (500 cycles).
- R5: While `sw_on` is 0, no current fault drives `flag_n` low, in the same cycle. A comparator that is high while the switch is off does not advance any set count.
- R6: When the off-time of a PWM waveform is shorter than the release delay, a qualified current fault stays held. `flag_n` then equals the inverse of `sw_on` cycle by cycle.
- R7: One edge after `temp_code` is at or above HOT_CODE (165), the thermal fault is held and `flag_n` is 0 regardless of `sw_on`.
- R8: A held thermal fault stays held while `temp_code` is above COOL_CODE (150). It is released at the edge where `temp_code` is at or below COOL_CODE.
- R9: While the thermal fault is held, `sw_out` is 0. At all other times `sw_out` equals `sw_on`.
- R10: A qualifying comparator pulse shorter than the set delay leaves `flag_n` at 1. When the comparator drops, the set count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_on | input | 1 | Switch-on command (constant-on or PWM on-portion) |
| oc_cmp | input | 1 | Over-current comparator, 1 = current above limit |
| uc_cmp | input | 1 | Under-current comparator, 1 = current below minimum |
| temp_code | input | TEMP_W | Unsigned die temperature code |
| sw_out | output | 1 | Switch command to the power stage, forced low by a thermal fault |
| flag_n | output | 1 | Fault flag, active low |

## Verification
The main function is exercised with several input patterns:
- A steady over-current with the switch on, which separates the set delay from the release delay.
- A comparator pulse shorter than the set delay, which shows that the count restarts rather than accumulating.
- A steady under-current, which checks the longer set delay against the shared release delay.
- A PWM switch pattern with a held over-current, which separates output gating from filter release.
- Comparators held high with the switch off, which checks the input masking.

A temperature ramp that stops one code short of each threshold checks the exact hysteresis boundaries. The same ramp also checks that the switch command is forced off while the thermal fault is held.

// File: rtl/fltq_pkg.sv
package fltq_pkg;

    // Converts a time in ns to a cycle count at the given clock in MHz (rounded up, at least 1).
    function automatic int unsigned ns_to_cyc(input int unsigned mhz, input int unsigned ns);
        int unsigned c;
        c = (mhz * ns + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fltq_filter.sv
module fltq_filter #(
    parameter int unsigned SET_CYC = 500,
    parameter int unsigned CLR_CYC = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic flt
);
    import fltq_pkg::*;

    localparam int unsigned MAXC = max2(SET_CYC, CLR_CYC);
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SET_LIM = CW'(SET_CYC - 1);
    localparam logic [CW-1:0] CLR_LIM = CW'(CLR_CYC - 1);

    typedef struct packed {
        logic          flt;
        logic [CW-1:0] cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw == st_q.flt) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == (st_q.flt ? CLR_LIM : SET_LIM)) begin
            st_d.flt = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt = st_q.flt;
endmodule

// File: rtl/fltq_thermal.sv
module fltq_thermal #(
    parameter int unsigned TEMP_W    = 8,
    parameter int unsigned HOT_CODE  = 165,
    parameter int unsigned COOL_CODE = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hot
);
    localparam logic [TEMP_W-1:0] HOT_TH  = TEMP_W'(HOT_CODE);
    localparam logic [TEMP_W-1:0] COOL_TH = TEMP_W'(COOL_CODE);

    typedef struct packed {
        logic hot;
    } therm_st_t;

    therm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.hot) st_d.hot = (temp_code > COOL_TH);
        else          st_d.hot = (temp_code >= HOT_TH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hot = st_q.hot;
endmodule

// File: rtl/fault_flag_qual.sv
module fault_flag_qual #(
    parameter int unsigned CLK_MHZ   = 250,
    parameter int unsigned OC_SET_NS = 2000,
    parameter int unsigned OC_CLR_NS = 2000,
    parameter int unsigned UC_SET_NS = 4000,
    parameter int unsigned UC_CLR_NS = 2000,
    parameter int unsigned TEMP_W    = 8,
    parameter int unsigned HOT_CODE  = 165,
    parameter int unsigned COOL_CODE = 150
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_on,
    input  logic              oc_cmp,
    input  logic              uc_cmp,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              sw_out,
    output logic              flag_n
);
    import fltq_pkg::*;

    localparam int unsigned OC_SET = ns_to_cyc(CLK_MHZ, OC_SET_NS);
    localparam int unsigned OC_CLR = ns_to_cyc(CLK_MHZ, OC_CLR_NS);
    localparam int unsigned UC_SET = ns_to_cyc(CLK_MHZ, UC_SET_NS);
    localparam int unsigned UC_CLR = ns_to_cyc(CLK_MHZ, UC_CLR_NS);

    logic oc_raw, uc_raw;
    logic oc_flt, uc_flt;
    logic hot;

    // Comparators only count while the switch conducts.
    assign oc_raw = oc_cmp & sw_on;
    assign uc_raw = uc_cmp & sw_on;

    fltq_filter #(.SET_CYC(OC_SET), .CLR_CYC(OC_CLR)) u_oc_filt (
        .clk(clk), .rst_n(rst_n), .raw(oc_raw), .flt(oc_flt)
    );

    fltq_filter #(.SET_CYC(UC_SET), .CLR_CYC(UC_CLR)) u_uc_filt (
        .clk(clk), .rst_n(rst_n), .raw(uc_raw), .flt(uc_flt)
    );

    fltq_thermal #(.TEMP_W(TEMP_W), .HOT_CODE(HOT_CODE), .COOL_CODE(COOL_CODE)) u_therm (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .hot(hot)
    );

    // Current faults are reported only during the on-time, so the flag pulses with PWM.
    assign flag_n = ~(hot | (sw_on & (oc_flt | uc_flt)));
    assign sw_out = sw_on & ~hot;
endmodule

// File: rtl/fault_flag_chk.sv
module fault_flag_chk #(
    parameter int unsigned TEMP_W    = 8,
    parameter int unsigned HOT_CODE  = 165,
    parameter int unsigned COOL_CODE = 150
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_on,
    input logic              oc_cmp,
    input logic [TEMP_W-1:0] temp_code,
    input logic              sw_out,
    input logic              flag_n,
    input logic              hot,
    input logic              oc_flt
);
    AST_THERM_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hot |-> (!sw_out && !flag_n)); // R9

    AST_OFF_MASKS_CURRENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_on && !hot) |-> flag_n); // R5

    AST_HOT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_code >= TEMP_W'(HOT_CODE)) |=> hot); // R7

    AST_HOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hot && temp_code > TEMP_W'(COOL_CODE)) |=> hot); // R8

    AST_OC_SET_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oc_flt) |-> $past(oc_cmp && sw_on)); // R2
endmodule

bind fault_flag_qual fault_flag_chk #(
    .TEMP_W(TEMP_W), .HOT_CODE(HOT_CODE), .COOL_CODE(COOL_CODE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .oc_cmp(oc_cmp),
    .temp_code(temp_code), .sw_out(sw_out), .flag_n(flag_n),
    .hot(hot), .oc_flt(oc_flt)
);

// File: tb/test_fault_flag_qual.sv
`timescale 1ns/1ps
module test_fault_flag_qual;
    localparam int OC_SET = 500, OC_CLR = 500, UC_SET = 1000, UC_CLR = 500;
    localparam int HOT = 165, COOL = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_on = 1'b0, oc_cmp = 1'b0, uc_cmp = 1'b0;
    logic [7:0] temp_code = 8'd25;
    logic sw_out, flag_n;

    int compared = 0, mismatched = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    // Behavioural reference state
    bit m_oc = 0, m_uc = 0, m_hot = 0;
    int oc_run = 0, uc_run = 0;

    always #2 clk = ~clk;

    fault_flag_qual i_fault_flag_qual (
        .clk(clk), .rst_n(rst_n), .sw_on(sw_on), .oc_cmp(oc_cmp), .uc_cmp(uc_cmp),
        .temp_code(temp_code), .sw_out(sw_out), .flag_n(flag_n)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_oc = 0; m_uc = 0; m_hot = 0; oc_run = 0; uc_run = 0;
        end else begin
            bit q_oc, q_uc;
            q_oc = oc_cmp && sw_on;
            q_uc = uc_cmp && sw_on;
            if (q_oc != m_oc) begin
                oc_run++;
                if (oc_run >= (m_oc ? OC_CLR : OC_SET)) begin m_oc = q_oc; oc_run = 0; end
            end else oc_run = 0;
            if (q_uc != m_uc) begin
                uc_run++;
                if (uc_run >= (m_uc ? UC_CLR : UC_SET)) begin m_uc = q_uc; uc_run = 0; end
            end else uc_run = 0;
            if (m_hot) m_hot = (int'(temp_code) > COOL);
            else       m_hot = (int'(temp_code) >= HOT);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic e_flag, e_sw;
            e_flag = !(m_hot || (sw_on && (m_oc || m_uc)));
            e_sw   = sw_on && !m_hot;
            compared++;
            if (flag_n !== e_flag || sw_out !== e_sw) begin
                mismatched++;
                $display("FAIL %s t=%0t flag_n=%b sw_out=%b expected flag_n=%b sw_out=%b",
                         cur_req, $time, flag_n, sw_out, e_flag, e_sw);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        // R1: quiet after reset, switch passes through
        cur_req = "R1"; wait_cyc(5);
        sw_on = 1'b1; wait_cyc(5);
        // R2: steady over-current qualifies after the set delay
        cur_req = "R2"; oc_cmp = 1'b1; wait_cyc(OC_SET + 100);
        // R3: release needs the full release delay
        cur_req = "R3"; oc_cmp = 1'b0; wait_cyc(OC_CLR - 100);
        wait_cyc(200);
        // R10: pulse shorter than set delay is rejected, count restarts
        cur_req = "R10"; oc_cmp = 1'b1; wait_cyc(OC_SET - 100);
        oc_cmp = 1'b0; wait_cyc(3);
        oc_cmp = 1'b1; wait_cyc(OC_SET - 100);
        oc_cmp = 1'b0; wait_cyc(50);
        // R4: under-current set and release
        cur_req = "R4"; uc_cmp = 1'b1; wait_cyc(UC_SET - 10);
        wait_cyc(50);
        uc_cmp = 1'b0; wait_cyc(UC_CLR + 50);
        // R6: PWM with held over-current, flag follows on-time
        cur_req = "R6"; oc_cmp = 1'b1; wait_cyc(OC_SET + 20);
        for (int p = 0; p < 10; p++) begin
            sw_on = 1'b0; wait_cyc(60);
            sw_on = 1'b1; wait_cyc(40);
        end
        // R5: switch off masks and lets the filter release
        cur_req = "R5"; sw_on = 1'b0; uc_cmp = 1'b1; wait_cyc(OC_CLR + 1500);
        sw_on = 1'b1; wait_cyc(10);
        sw_on = 1'b0; wait_cyc(20);
        oc_cmp = 1'b0; uc_cmp = 1'b0;
        // R7 and R9: thermal threshold and forced-off switch
        cur_req = "R7"; sw_on = 1'b1; temp_code = 8'(HOT - 1); wait_cyc(20);
        temp_code = 8'(HOT); wait_cyc(20);
        cur_req = "R9"; sw_on = 1'b0; wait_cyc(5); sw_on = 1'b1; wait_cyc(5);
        // R8: hysteresis release
        cur_req = "R8"; temp_code = 8'(COOL + 1); wait_cyc(30);
        temp_code = 8'(COOL); wait_cyc(20);
        temp_code = 8'(HOT - 1); wait_cyc(20);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule